// File: doc/BRIEF.md
# Microframe Frame Index Counter

This block holds the frame index counter that a periodic-schedule engine uses to address its frame list. The counter is 14 bits wide. It advances by one on each microframe tick, which arrives every 125 µs, while the controller is not halted. The three low bits count microframes within a frame. The bits above them give the frame-list entry index. The width of that index is set by a 2-bit list-size code.

Software sees the counter through a 32-bit register port. A read returns the count, zero-extended. A write loads the count, but only when three conditions hold: the controller reports halted, the run bit is clear, and all four byte enables are set. Any other write is dropped. The start-of-frame value, which is the count with its microframe bits removed, follows every change of the counter. It covers both increments and accepted writes.

Top module: `uframe_index_ctr`

## Requirements
- R1: After reset the count is 0, so `reg_rdata`, `flist_idx` and `sof_val` read 0.
- R2: A cycle with `uframe_tick`=1 and `halted`=0 raises the count by one. A tick while `halted`=1 leaves the count unchanged.
- R3: An increment from 16383 wraps the count to 0.
- R4: `reg_rdata` always equals the 14-bit count in bits 13..0, with bits 31..14 zero.
- R5: With `fls_code`=00 (1024 entries), `flist_idx` equals count bits 12..3.
- R6: With `fls_code`=01 (512 entries), `flist_idx` bits 8..0 equal count bits 11..3, and bit 9 is 0.
- R7: With `fls_code`=10 (256 entries), `flist_idx` bits 7..0 equal count bits 10..3, and bits 9..8 are 0.
- R8: `fls_code`=11 is a reserved code and behaves exactly like 00.
- R9: A write with `reg_wr`=1, `reg_be`=1111, `halted`=1 and `run_en`=0 loads `reg_wdata[13:0]` into the count. The new value is visible after the next clock edge.
- R10: A write while `run_en`=1 leaves the count unchanged.
- R11: A write while `halted`=0 leaves the count unchanged. Ticks still apply as in R2.
- R12: A write whose `reg_be` is not 1111 leaves the count unchanged.
- R13: `sof_val` always equals count bits 13..3. It therefore follows both increments and accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_tick | input | 1 | One-cycle pulse per 125 µs microframe |
| run_en | input | 1 | Run bit of the controller command state |
| halted | input | 1 | Controller halted status |
| fls_code | input | 2 | Frame-list size code: 00=1024, 01=512, 10=256, 11=1024 |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Zero-extended count |
| flist_idx | output | 10 | Frame-list entry index |
| sof_val | output | 11 | Start-of-frame value |

## Verification
The assertions assume that every input is a known 0 or 1 from reset onward. They also assume that `reg_wdata` and `reg_be` are meaningful only in cycles where `reg_wr` is set. They do not assume that `run_en` and `halted` are exclusive, so the stop and start windows are covered. In those windows both flags can be high or both low. The stimulus drives every input at each falling edge from time zero and sweeps all four run/halted combinations. It also mixes ticks with full and partial writes, including a write and a tick in the same cycle.

// File: rtl/fidx_pkg.sv
package fidx_pkg;

    // Frame-list size codes and the count layout shared by the block.
    typedef enum logic [1:0] {
        FLS_1024 = 2'b00,
        FLS_512  = 2'b01,
        FLS_256  = 2'b10,
        FLS_RSVD = 2'b11
    } fls_e;

    localparam int CNT_W_DEF   = 14;
    localparam int UF_BITS_DEF = 3;
    localparam int IDX_W_DEF   = 10;
    localparam int REG_W_DEF   = 32;

endpackage

// File: rtl/fidx_wr_gate.sv
module fidx_wr_gate #(
    parameter int REG_W = 32,
    localparam int BE_W = REG_W / 8
) (
    input  logic            reg_wr,
    input  logic [BE_W-1:0] reg_be,
    input  logic            halted,
    input  logic            run_en,
    output logic            wr_ok
);

    logic full_word;

    always_comb begin
        full_word = &reg_be;
        wr_ok     = reg_wr && full_word && halted && !run_en;
    end

endmodule

// File: rtl/fidx_core.sv
module fidx_core #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uframe_tick,
    input  logic             halted,
    input  logic             wr_ok,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            st_d.count = wr_val;
        end else if (uframe_tick && !halted) begin
            st_d.count = st_q.count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;

endmodule

// File: rtl/fidx_index_sel.sv
module fidx_index_sel
    import fidx_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] frame_bits,
    input  logic [1:0]       fls_code,
    output logic [IDX_W-1:0] flist_idx
);

    logic [IDX_W-1:0] idx_full, idx_half, idx_quarter;

    for (genvar i = 0; i < IDX_W; i++) begin : g_bit
        assign idx_full[i] = frame_bits[i];
        if (i < IDX_W - 1) begin : g_half_keep
            assign idx_half[i] = frame_bits[i];
        end else begin : g_half_zero
            assign idx_half[i] = 1'b0;
        end
        if (i < IDX_W - 2) begin : g_qtr_keep
            assign idx_quarter[i] = frame_bits[i];
        end else begin : g_qtr_zero
            assign idx_quarter[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (fls_e'(fls_code))
            FLS_512:  flist_idx = idx_half;
            FLS_256:  flist_idx = idx_quarter;
            default:  flist_idx = idx_full;
        endcase
    end

endmodule

// File: rtl/uframe_index_ctr.sv
module uframe_index_ctr
    import fidx_pkg::*;
#(
    parameter int CNT_W   = CNT_W_DEF,
    parameter int UF_BITS = UF_BITS_DEF,
    parameter int IDX_W   = IDX_W_DEF,
    parameter int REG_W   = REG_W_DEF,
    localparam int SOF_W  = CNT_W - UF_BITS,
    localparam int BE_W   = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             uframe_tick,
    input  logic             run_en,
    input  logic             halted,
    input  logic [1:0]       fls_code,
    input  logic             reg_wr,
    input  logic [BE_W-1:0]  reg_be,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [IDX_W-1:0] flist_idx,
    output logic [SOF_W-1:0] sof_val
);

    logic             wr_ok;
    logic [CNT_W-1:0] count;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[REG_W-1:CNT_W];

    fidx_wr_gate #(.REG_W(REG_W)) u_gate (
        .reg_wr (reg_wr),
        .reg_be (reg_be),
        .halted (halted),
        .run_en (run_en),
        .wr_ok  (wr_ok)
    );

    fidx_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .uframe_tick (uframe_tick),
        .halted      (halted),
        .wr_ok       (wr_ok),
        .wr_val      (reg_wdata[CNT_W-1:0]),
        .count       (count)
    );

    fidx_index_sel #(.IDX_W(IDX_W)) u_idx (
        .frame_bits (count[UF_BITS+IDX_W-1:UF_BITS]),
        .fls_code   (fls_code),
        .flist_idx  (flist_idx)
    );

    assign reg_rdata = {{(REG_W-CNT_W){1'b0}}, count};
    assign sof_val   = count[CNT_W-1:UF_BITS];

endmodule

// File: rtl/fidx_chk.sv
module fidx_chk #(
    parameter int CNT_W   = 14,
    parameter int UF_BITS = 3,
    parameter int IDX_W   = 10,
    parameter int REG_W   = 32,
    localparam int SOF_W  = CNT_W - UF_BITS,
    localparam int BE_W   = REG_W / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             uframe_tick,
    input logic             run_en,
    input logic             halted,
    input logic [1:0]       fls_code,
    input logic             reg_wr,
    input logic [BE_W-1:0]  reg_be,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic [IDX_W-1:0] flist_idx,
    input logic [SOF_W-1:0] sof_val
);

    logic tick_live;
    logic full_be;
    assign tick_live = uframe_tick && !halted;
    assign full_be   = (reg_be == {BE_W{1'b1}});

    // R2
    tick_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_live && !reg_wr |=> reg_rdata[CNT_W-1:0] == CNT_W'($past(reg_rdata[CNT_W-1:0]) + 1));

    // R2
    tick_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uframe_tick && halted && !(reg_wr && full_be && !run_en) |=> $stable(reg_rdata));

    // R4
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:CNT_W] == '0);

    // R7
    idx_256_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fls_code == 2'b10 |-> flist_idx[IDX_W-1:IDX_W-2] == 2'b00);

    // R9
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && full_be && halted && !run_en
        |=> reg_rdata[CNT_W-1:0] == $past(reg_wdata[CNT_W-1:0]));

    // R10
    write_run_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && run_en && !tick_live |=> $stable(reg_rdata));

    // R11
    write_busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !halted && !uframe_tick |=> $stable(reg_rdata));

    // R12
    write_partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !full_be && !tick_live |=> $stable(reg_rdata));

    // R13
    sof_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof_val == reg_rdata[CNT_W-1:UF_BITS]);

endmodule

bind uframe_index_ctr fidx_chk #(
    .CNT_W(CNT_W), .UF_BITS(UF_BITS), .IDX_W(IDX_W), .REG_W(REG_W)
) u_fidx_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .uframe_tick (uframe_tick),
    .run_en      (run_en),
    .halted      (halted),
    .fls_code    (fls_code),
    .reg_wr      (reg_wr),
    .reg_be      (reg_be),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .flist_idx   (flist_idx),
    .sof_val     (sof_val)
);

// File: tb/uframe_index_ctr_bench.sv
module uframe_index_ctr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uframe_tick = 1'b0;
    logic        run_en = 1'b0;
    logic        halted = 1'b1;
    logic [1:0]  fls_code = 2'b00;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [9:0]  flist_idx;
    logic [10:0] sof_val;

    int checks = 0;
    int failures = 0;
    int model = 0;
    bit done = 0;
    string phase = "R4";

    always #2 clk = ~clk;

    uframe_index_ctr u_uframe_index_ctr (
        .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick), .run_en(run_en),
        .halted(halted), .fls_code(fls_code), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flist_idx(flist_idx),
        .sof_val(sof_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int w;
        string itag;
        case (fls_code)
            2'b01: begin w = 9; itag = "R6"; end
            2'b10: begin w = 8; itag = "R7"; end
            2'b11: begin w = 10; itag = "R8"; end
            default: begin w = 10; itag = "R5"; end
        endcase
        chk(phase, reg_rdata, 32'(model));
        chk(itag, 32'(flist_idx), 32'((model >> 3) & ((1 << w) - 1)));
        chk("R13", 32'(sof_val), 32'(model >> 3));
    endtask

    task automatic cyc(input bit tk, input bit run, input bit hlt, input logic [1:0] fls,
                       input bit wr, input logic [3:0] be, input logic [31:0] wd);
        uframe_tick = tk; run_en = run; halted = hlt; fls_code = fls;
        reg_wr = wr; reg_be = be; reg_wdata = wd;
        @(posedge clk);
        if (wr && be == 4'hF && hlt && !run) model = int'(wd & 32'h3FFF);
        else if (tk && !hlt) model = (model + 1) % 16384;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        compare_all();
        chk("R1", reg_rdata, 32'h0);

        // R9: halted full write loads, upper data bits dropped (R4)
        phase = "R9";
        cyc(0, 0, 1, 2'b00, 1, 4'hF, 32'hFFFF_3FF8);
        chk("R9", reg_rdata, 32'h3FF8);
        // R2: tick while halted does nothing
        phase = "R2";
        cyc(1, 0, 1, 2'b00, 0, 4'h0, 0);
        chk("R2", reg_rdata, 32'h3FF8);
        // R12: partial write ignored
        phase = "R12";
        cyc(0, 0, 1, 2'b00, 1, 4'h7, 32'h123);
        cyc(0, 0, 1, 2'b00, 1, 4'hE, 32'h456);
        chk("R12", reg_rdata, 32'h3FF8);
        // load a known value, then run
        phase = "R9";
        cyc(0, 0, 1, 2'b00, 1, 4'hF, 32'h0F5C);
        phase = "R2";
        for (int i = 0; i < 10; i++) cyc(1, 1, 0, 2'(i % 4), 0, 4'h0, 0);
        chk("R2", reg_rdata, 32'h0F66);
        // index sizes on a value with all index bits set
        phase = "R9";
        cyc(0, 0, 1, 2'b00, 1, 4'hF, 32'h1FF8);
        phase = "R5";
        cyc(0, 0, 1, 2'b00, 0, 4'h0, 0);
        chk("R5", 32'(flist_idx), 32'h3FF);
        cyc(0, 0, 1, 2'b01, 0, 4'h0, 0);
        chk("R6", 32'(flist_idx), 32'h1FF);
        cyc(0, 0, 1, 2'b10, 0, 4'h0, 0);
        chk("R7", 32'(flist_idx), 32'h0FF);
        cyc(0, 0, 1, 2'b11, 0, 4'h0, 0);
        chk("R8", 32'(flist_idx), 32'h3FF);
        // R10: write while running, no tick
        phase = "R10";
        cyc(0, 1, 0, 2'b00, 1, 4'hF, 32'h0001);
        cyc(0, 1, 1, 2'b00, 1, 4'hF, 32'h0002);
        chk("R10", reg_rdata, 32'h1FF8);
        // R11: write while not halted, run clear
        phase = "R11";
        cyc(0, 0, 0, 2'b00, 1, 4'hF, 32'h0003);
        chk("R11", reg_rdata, 32'h1FF8);
        cyc(1, 0, 0, 2'b00, 1, 4'hF, 32'h0004);
        chk("R11", reg_rdata, 32'h1FF9);
        // R3: wrap
        phase = "R9";
        cyc(0, 0, 1, 2'b00, 1, 4'hF, 32'h3FFE);
        phase = "R3";
        cyc(1, 1, 0, 2'b00, 0, 4'h0, 0);
        cyc(1, 1, 0, 2'b00, 0, 4'h0, 0);
        chk("R3", reg_rdata, 32'h0);
        chk("R13", 32'(sof_val), 32'h0);
        cyc(1, 1, 0, 2'b00, 0, 4'h0, 0);
        chk("R3", reg_rdata, 32'h1);
        // mixed stimulus against the model
        phase = "R4";
        for (int i = 0; i < 3000; i++) begin
            bit tk, run, hlt, wr;
            logic [3:0] be;
            tk  = ($urandom % 3) != 0;
            run = $urandom % 2;
            hlt = ($urandom % 4 == 0) ? run : !run;
            wr  = ($urandom % 5) == 0;
            be  = ($urandom % 2) ? 4'hF : 4'($urandom);
            cyc(tk, run, hlt, 2'($urandom), wr, be, $urandom);
        end
        // R1: reset mid-run returns to zero
        rst_n = 1'b0;
        @(posedge clk);
        model = 0;
        @(negedge clk);
        rst_n = 1'b1;
        phase = "R1";
        compare_all();
        chk("R1", reg_rdata, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule